// File: doc/BRIEF.md
# I2C Register Target with High-Speed Entry

This block is the byte-level serial bus front end of a data converter. It watches the bus clock and data lines, which arrive oversampled by the system clock. It finds start and stop conditions and decodes each byte that a controller sends. It acknowledges only its own 7-bit address. It answers a read with the latest 16-bit conversion result and then the configuration byte. A write loads the configuration byte, and from that byte the block passes a conversion start request to the conversion controller.

A byte of the form `00001xxx` that follows a start is a high-speed entry code. The block never acknowledges this code. It raises a high-speed flag that stays set across repeated starts until the next stop condition. Other logic can use this flag to retune input filtering. The data line is modelled as open drain: the block only pulls it low through an active-low output enable.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset the configuration fields are single-shot mode 0, rate code 2'b11 and gain code 2'b00, so the configuration byte reads back as 0x8C. The high-speed flag is 0 and the data line is released (`sda_oe_n` = 1).
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Either one clears the bit and byte progress at once, and the next bits are taken as a fresh address byte. After a stop the data line is released.
- R3: A byte whose upper five bits are 00001, sent right after a start, is not acknowledged. Its low bit is not taken as read/write. It sets `hs_mode`, which stays 1 through repeated starts and returns to 0 on the next stop.
- R4: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and the block stays silent until the next start.
- R5: In a write, the first data byte is acknowledged and loads the configuration. Bit 4 goes to `conv_single`, bits 3:2 go to `conv_rate` and bits 1:0 go to `conv_gain`. Bits 6:5 are ignored.
- R6: A written byte with bit 7 = 1 and bit 4 = 1 gives exactly one single-cycle `conv_start` pulse. Bit 7 gives no pulse when bit 4 = 0, and bit 7 is never stored.
- R7: A read returns the bytes in this order, each sent MSB first: result bits 15:8, result bits 7:0, then the configuration byte `{status, 2'b00, single, rate, gain}`. The 16-bit result is captured once, when the address is acknowledged.
- R8: The status bit (bit 7) of the configuration byte that is read back equals `busy_i` in single-shot mode and is 1 in continuous mode.
- R9: Every read byte after the third repeats the configuration byte. A not-acknowledge from the controller, after any byte including the second, ends the read and releases SDA.
- R10: A second data byte in the same write is not acknowledged and leaves the configuration unchanged.
- R11: The block changes its SDA drive only while SCL is low, so SDA stays constant through every SCL high phase it drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line |
| result_i | input | 16 | Latest conversion result, two's complement |
| busy_i | input | 1 | Conversion in progress, from the conversion controller |
| hs_mode | output | 1 | High-speed entry seen; held until the next stop |
| conv_single | output | 1 | 1 = single-shot mode, 0 = continuous mode |
| conv_rate | output | 2 | Data rate code |
| conv_gain | output | 2 | Gain code |
| conv_start | output | 1 | One-cycle conversion start request |

## Verification
A wrong bit counter or a wrong protocol state shows at SDA within one byte. The acknowledge slot of that byte either goes missing or turns up in the wrong place, and read data arrives shifted. A stuck high-speed flag shows at `hs_mode` on the cycle after a stop has been decoded. Errors in the configuration register reach `conv_*` a few cycles after the falling SCL edge that closes the data byte. They also reach the configuration byte on the next read. The bench sweeps every write value, reads back at intervals, and checks acknowledge timing, byte order and SDA stability during each high phase that the block drives.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int RES_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WDATA,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;

  typedef struct packed {
    logic       single;
    logic [1:0] rate;
    logic [1:0] gain;
  } cfg_t;

  localparam logic [4:0] HS_CODE_TOP = 5'b00001;
  localparam cfg_t       CFG_RESET   = '{single: 1'b0, rate: 2'b11, gain: 2'b00};

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= INIT;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_cfg.sv
module i2c_tgt_cfg
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output cfg_t              cfg_q,
  output logic              start_req
);
  logic unused_rsv;
  assign unused_rsv = ^wr_byte[6:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RESET;
      start_req <= 1'b0;
    end else begin
      start_req <= wr_en & wr_byte[7] & wr_byte[4];
      if (wr_en) cfg_q <= '{single: wr_byte[4], rate: wr_byte[3:2], gain: wr_byte[1:0]};
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_req |-> cfg_q.single); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !start_req); // R6
endmodule

// File: rtl/i2c_tgt_proto.sv
module i2c_tgt_proto
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_s,
  input  logic [RES_W-1:0]  result_i,
  input  logic [BYTE_W-1:0] cfg_byte,
  output logic              sda_oe_n,
  output logic              hs_mode,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [RES_W-1:0]  snap;
  logic [1:0]        byte_idx;
  logic              rw, m_ack, got_data;
  logic [BYTE_W-1:0] next_tx;

  assign next_tx = (byte_idx == 2'd1) ? snap[BYTE_W-1:0] : cfg_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      snap     <= '0;
      byte_idx <= '0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      got_data <= 1'b0;
      sda_oe_n <= 1'b1;
      hs_mode  <= 1'b0;
      wr_en    <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_stop) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe_n <= 1'b1;
        hs_mode  <= 1'b0;
      end else if (bus_start) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_n <= 1'b1;
        got_data <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:3] == HS_CODE_TOP) begin
                  hs_mode <= 1'b1;
                  state   <= ST_IGNORE;
                end else if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe_n <= 1'b0;
                  rw       <= shreg[0];
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (!got_data) begin
                sda_oe_n <= 1'b0;
                wr_en    <= 1'b1;
                wr_byte  <= shreg;
                got_data <= 1'b1;
                state    <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                snap     <= result_i;
                byte_idx <= 2'd1;
                shreg    <= result_i[RES_W-1:BYTE_W];
                sda_oe_n <= result_i[RES_W-1];
                bit_cnt  <= '0;
                state    <= ST_TX;
              end else begin
                sda_oe_n <= 1'b1;
                state    <= ST_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == LAST) begin
                sda_oe_n <= 1'b1;
                state    <= ST_RACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe_n <= shreg[BYTE_W-2];
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                shreg    <= next_tx;
                sda_oe_n <= next_tx[BYTE_W-1];
                bit_cnt  <= '0;
                byte_idx <= 2'd2;
                state    <= ST_TX;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_HS_STOP_CLR: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !hs_mode); // R3
  AST_HS_STICKY: assert property (@(posedge clk) disable iff (rst)
    hs_mode && !bus_stop |=> hs_mode); // R3
  AST_HS_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> sda_oe_n); // R3
  AST_START_RESYNC: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (state == ST_ADDR && bit_cnt == '0 && sda_oe_n)); // R2
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> (state == ST_IDLE && sda_oe_n)); // R2
  AST_WR_ACKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !sda_oe_n); // R5
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_n) |-> $past(scl_fall || bus_start || bus_stop)); // R11
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_n,
  input  logic [15:0] result_i,
  input  logic        busy_i,
  output logic        hs_mode,
  output logic        conv_single,
  output logic [1:0]  conv_rate,
  output logic [1:0]  conv_gain,
  output logic        conv_start
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [BYTE_W-1:0] wr_byte, cfg_byte;
  cfg_t cfg_q;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  i2c_tgt_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop));

  assign cfg_byte = {(cfg_q.single ? busy_i : 1'b1), 2'b00,
                     cfg_q.single, cfg_q.rate, cfg_q.gain};

  i2c_tgt_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s),
    .result_i(result_i), .cfg_byte(cfg_byte),
    .sda_oe_n(sda_oe_n), .hs_mode(hs_mode),
    .wr_en(wr_en), .wr_byte(wr_byte));

  i2c_tgt_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .cfg_q(cfg_q), .start_req(conv_start));

  assign conv_single = cfg_q.single;
  assign conv_rate   = cfg_q.rate;
  assign conv_gain   = cfg_q.gain;
endmodule

// File: tb/i2c_hs_target_tb.sv
module i2c_hs_target_tb;
  localparam logic [6:0] ADDR = 7'h48;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_n, sda_bus;
  logic [15:0] result = 16'h0;
  logic busy = 1'b0;
  logic hs, single, start;
  logic [1:0] rate, gain;
  logic [7:0] rbuf [0:5];
  int errors = 0, checks = 0, pulses = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & sda_oe_n;

  i2c_hs_target #(.DEV_ADDR(ADDR)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_n(sda_oe_n),
    .result_i(result), .busy_i(busy), .hs_mode(hs), .conv_single(single),
    .conv_rate(rate), .conv_gain(gain), .conv_start(start));

  always @(negedge clk) if (!rst && start) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(2);
  endtask

  task automatic bstop;
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic wbit(input bit b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(2);
  endtask

  task automatic rbit(output bit b);
    bit s0;
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(1);
    s0 = sda_bus; tick(H - 2); b = sda_bus;
    if (s0 !== b) chk("R11 sda stable while scl high", {31'd0, b}, {31'd0, s0});
    tick(1); scl_m = 1'b0; tick(2);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~mack);
  endtask

  task automatic cfg_write(input logic [7:0] v, output bit a1, output bit a2);
    bstart; wbyte({ADDR, 1'b0}, a1); wbyte(v, a2); bstop;
  endtask

  task automatic do_read(input int n, output bit aack);
    logic [7:0] d;
    bstart; wbyte({ADDR, 1'b1}, aack);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      rbuf[i] = d;
    end
    bstop;
  endtask

  function automatic logic [7:0] exp_cfg(input logic [4:0] f, input logic b);
    return {(f[4] ? b : 1'b1), 2'b00, f};
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run;
    end
  end

  initial begin
    bit a1, a2;
    int p0;
    logic [4:0] mdl;
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    chk("R1 cfg fields", {27'd0, single, rate, gain}, 32'h0C);
    chk("R1 hs flag", {31'd0, hs}, 32'd0);
    chk("R1 sda released", {31'd0, sda_oe_n}, 32'd1);
    chk("R1 no start", {31'd0, start}, 32'd0);

    // R7 R8 read order after reset, continuous mode status is 1
    result = 16'hBEEF;
    do_read(3, a1);
    chk("R4 read address ack", {31'd0, a1}, 32'd1);
    chk("R7 byte0", {24'd0, rbuf[0]}, 32'hBE);
    chk("R7 byte1", {24'd0, rbuf[1]}, 32'hEF);
    chk("R1 R8 cfg byte", {24'd0, rbuf[2]}, 32'h8C);
    chk("R9 released after read", {31'd0, sda_oe_n}, 32'd1);

    // R4 wrong addresses
    bstart; wbyte({ADDR ^ 7'h01, 1'b0}, a1); bstop;
    chk("R4 mismatch nack", {31'd0, a1}, 32'd0);
    bstart; wbyte({ADDR ^ 7'h40, 1'b1}, a1); bstop;
    chk("R4 mismatch nack read", {31'd0, a1}, 32'd0);

    // R3 high-speed entry
    bstart; wbyte(8'h0B, a1);
    chk("R3 master code nack", {31'd0, a1}, 32'd0);
    chk("R3 hs set", {31'd0, hs}, 32'd1);
    bstart;
    chk("R3 hs kept over repeated start", {31'd0, hs}, 32'd1);
    wbyte({ADDR, 1'b0}, a1); wbyte(8'h05, a2);
    chk("R3 R4 addressed in hs", {30'd0, a1, a2}, 32'd3);
    chk("R3 hs held before stop", {31'd0, hs}, 32'd1);
    bstop;
    chk("R3 hs cleared by stop", {31'd0, hs}, 32'd0);
    chk("R5 cfg in hs", {27'd0, single, rate, gain}, 32'h05);

    // R5 R6 R7 R8 sweep of every write value
    for (int v = 0; v < 256; v++) begin
      p0 = pulses;
      cfg_write(8'(v), a1, a2);
      mdl = 5'(v);
      chk("R5 write acks", {30'd0, a1, a2}, 32'd3);
      chk("R5 cfg fields", {27'd0, single, rate, gain}, {27'd0, mdl});
      chk("R6 start pulses", pulses - p0, {31'd0, (v[7] & v[4]) ? 1'b1 : 1'b0});
      if (v[3:0] == 4'h5) begin
        busy = v[5];
        result = {8'(v), ~8'(v)};
        do_read(3, a1);
        chk("R7 sweep byte0", {24'd0, rbuf[0]}, v);
        chk("R7 sweep byte1", {24'd0, rbuf[1]}, {24'd0, ~8'(v)});
        chk("R8 sweep cfg byte", {24'd0, rbuf[2]}, {24'd0, exp_cfg(mdl, v[5])});
      end
    end

    // R10 second data byte refused
    p0 = pulses;
    bstart; wbyte({ADDR, 1'b0}, a1); wbyte(8'h13, a2);
    chk("R10 first byte ack", {30'd0, a1, a2}, 32'd3);
    wbyte(8'h9E, a2); bstop;
    chk("R10 second byte nack", {31'd0, a2}, 32'd0);
    chk("R10 cfg unchanged", {27'd0, single, rate, gain}, 32'h13);
    chk("R10 no start from second byte", pulses - p0, 32'd0);

    // R9 long read repeats cfg, short read ends cleanly
    busy = 1'b1; result = 16'h1234;
    do_read(5, a1);
    chk("R9 byte0", {24'd0, rbuf[0]}, 32'h12);
    chk("R9 byte3 repeats cfg", {24'd0, rbuf[3]}, {24'd0, exp_cfg(5'h13, 1'b1)});
    chk("R9 byte4 repeats cfg", {24'd0, rbuf[4]}, {24'd0, exp_cfg(5'h13, 1'b1)});
    result = 16'h8001;
    do_read(2, a1);
    chk("R9 two-byte read", {16'd0, rbuf[0], rbuf[1]}, 32'h8001);
    chk("R9 released after short read", {31'd0, sda_oe_n}, 32'd1);

    // R2 stop mid-address and start mid-data restart the byte engine
    bstart; wbit(1'b1); wbit(1'b0); wbit(1'b0); wbit(1'b1); bstop;
    chk("R2 released after stop", {31'd0, sda_oe_n}, 32'd1);
    bstart; wbyte({ADDR, 1'b0}, a1); wbit(1'b1); wbit(1'b1); wbit(1'b0);
    bstart; wbyte({ADDR, 1'b0}, a1); wbyte(8'h0A, a2); bstop;
    chk("R2 restart acks", {30'd0, a1, a2}, 32'd3);
    chk("R2 cfg after restart", {27'd0, single, rate, gain}, 32'h0A);

    done = 1'b1;
    finish_run;
  end
endmodule